// File: doc/BRIEF.md
# Lower-Part Approximate Ripple Adder

This block adds two N-bit operands and a carry-in. It builds the result from a chain of one-bit cells. The lowest `APPROX_BITS` positions use an approximate cell. The remaining upper positions use exact full adders. The carry leaving the most significant approximate cell enters the least significant exact cell. A parameter selects one of two approximate cells:

- **Carry-predicting cell.** It forms its carry from the two operand bits alone, so no carry ripples through the lower segment.
- **Sum-from-carry cell.** It keeps an exact majority carry and takes the sum as the inverse of that carry.

The block is purely combinational. It has no handshake and no registers, so the operands flow straight through to the sum and carry-out. Setting `APPROX_BITS` to half of `WIDTH` gives half prediction. Setting it to `WIDTH` makes every position approximate. Zero gives an exact adder. Any value in between is legal. Integrators use it where a filter or accumulator can tolerate error in the low bits in exchange for a shorter carry path.

Top module: `lpa_adder`

## Requirements
- R1: With `APPROX_BITS` = 0, `{carry_out, sum}` equals `op_a + op_b + carry_in` exactly, at every width.
- R2: In a carry-predicting position i, the sum bit is `op_a[i] ^ op_b[i] ^ c_i`. Its outgoing carry is `op_a[i] & op_b[i]` whatever `c_i` is. Here `c_0` is `carry_in`. For example, at WIDTH 12 with 6 such cells, 0x001 + 0x000 + 1 gives sum 0x000 with carry_out 0.
- R3: In a sum-from-carry position, the outgoing carry is the majority of the two operand bits and the incoming carry, and the sum bit is the inverse of that carry. So the sum is wrong only for the input triples all-zero and all-ones, and the carry is always right.
- R4: Positions `APPROX_BITS` to `WIDTH-1` form an exact adder. Its carry-in is the carry out of position `APPROX_BITS-1`, or `carry_in` when there are no approximate positions. `carry_out` is that adder's carry.
- R5: With `APPROX_BITS` = `WIDTH`, `carry_out` is the outgoing carry of the most significant approximate cell. For the carry-predicting cell this is `op_a[WIDTH-1] & op_b[WIDTH-1]`.
- R6: Half prediction (`APPROX_BITS` = `WIDTH/2`) follows R2 to R4 for both cell types.
- R7: Intermediate settings, for example 8 or 10 approximate positions out of 12, follow R2 to R4.
- R8: Any `WIDTH` of 1 or more works, including 8, 12, 24 and 32, with any `APPROX_BITS` from 0 to `WIDTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into position 0 |
| sum | output | WIDTH | Approximate sum |
| carry_out | output | 1 | Carry out of position WIDTH-1 |

## Verification
The bench places eight copies of the adder side by side:

- 12 bits with 6 approximate positions, once for each cell type;
- 12 of 12 carry-predicting;
- 8 of 8 sum-from-carry;
- 12 bits with 10 sum-from-carry and with 8 carry-predicting positions;
- 24 bits with 12 carry-predicting positions;
- an exact 32-bit adder.

Together these cover both cell types, the half, full and intermediate splits, zero and full approximation, and the 8, 12, 24 and 32-bit widths. Across them the boundary carry meets the exact segment in every form it can take. The 32-bit exact copy is compared against plain arithmetic. The others are compared against a per-bit cell model, and the bench also prints each copy's normalised mean error distance.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  typedef enum logic [0:0] {
    CELL_CARRY_PREDICT  = 1'b0,
    CELL_SUM_FROM_CARRY = 1'b1
  } cell_kind_e;
endpackage

// File: rtl/lpa_exact_cell.sv
module lpa_exact_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/lpa_approx_cell.sv
module lpa_approx_cell
  import lpa_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_CARRY_PREDICT
) (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  generate
    if (KIND == CELL_CARRY_PREDICT) begin : g_cp
      // carry predicted from operands alone: no ripple (R2)
      assign s  = (ci ^ x) ^ y;
      assign co = x & y;
    end else begin : g_sfc
      // exact majority carry, sum is its inverse (R3)
      logic maj;
      assign maj = (x & y) | (x & ci) | (y & ci);
      assign co  = maj;
      assign s   = ~maj;
    end
  endgenerate
endmodule

// File: rtl/lpa_adder.sv
module lpa_adder
  import lpa_pkg::*;
#(
  parameter int         WIDTH       = 12,
  parameter int         APPROX_BITS = WIDTH / 2,
  parameter cell_kind_e CELL_KIND   = CELL_CARRY_PREDICT
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int EXACT_BITS = WIDTH - APPROX_BITS;

  // carry entering the exact segment (R4)
  logic seg_carry;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic ci, s, co;
    if (i == 0) begin : g_first
      assign ci = carry_in;
    end else begin : g_link
      assign ci = g_bit[i-1].co;
    end
    if (i < APPROX_BITS) begin : g_apx
      lpa_approx_cell #(.KIND(CELL_KIND)) u_cell (
        .x(op_a[i]), .y(op_b[i]), .ci(ci), .s(s), .co(co)
      );
    end else begin : g_exa
      lpa_exact_cell u_cell (
        .x(op_a[i]), .y(op_b[i]), .ci(ci), .s(s), .co(co)
      );
    end
    assign sum[i] = s;
  end

  if (APPROX_BITS == 0) begin : g_no_apx
    assign seg_carry = carry_in;
  end else begin : g_seg
    assign seg_carry = g_bit[APPROX_BITS-1].co;
  end

  if (EXACT_BITS < 0) begin : g_bad_cfg
    initial $error("APPROX_BITS exceeds WIDTH");
  end

  assign carry_out = g_bit[WIDTH-1].co;
endmodule

// File: rtl/lpa_adder_checker.sv
module lpa_adder_checker
  import lpa_pkg::*;
#(
  parameter int         WIDTH       = 12,
  parameter int         APPROX_BITS = WIDTH / 2,
  parameter cell_kind_e CELL_KIND   = CELL_CARRY_PREDICT
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             seg_carry
);
  localparam int UW = WIDTH - APPROX_BITS;

  if (APPROX_BITS == 0) begin : g_r1
    always_comb begin
      assert_exact_R1: assert ({carry_out, sum} ==
        ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
        else $error("R1 exact adder mismatch");
    end
  end

  if (APPROX_BITS < WIDTH) begin : g_r4
    always_comb begin
      assert_upper_exact_R4: assert ({carry_out, sum[WIDTH-1:APPROX_BITS]} ==
        ({1'b0, op_a[WIDTH-1:APPROX_BITS]} + {1'b0, op_b[WIDTH-1:APPROX_BITS]}
         + {{UW{1'b0}}, seg_carry}))
        else $error("R4 exact segment mismatch");
    end
  end

  if (APPROX_BITS > 0 && CELL_KIND == CELL_CARRY_PREDICT) begin : g_r2
    logic [APPROX_BITS-1:0] want;
    always_comb begin
      want[0] = op_a[0] ^ op_b[0] ^ carry_in;
      for (int i = 1; i < APPROX_BITS; i++)
        want[i] = op_a[i] ^ op_b[i] ^ (op_a[i-1] & op_b[i-1]);
      assert_cp_sum_R2: assert (sum[APPROX_BITS-1:0] == want)
        else $error("R2 predicted sum mismatch");
      assert_cp_carry_R2: assert (seg_carry ==
        (op_a[APPROX_BITS-1] & op_b[APPROX_BITS-1]))
        else $error("R2 predicted carry mismatch");
    end
  end

  if (APPROX_BITS > 0 && CELL_KIND == CELL_SUM_FROM_CARRY) begin : g_r3
    logic [APPROX_BITS-1:0] want;
    logic                   c_low;
    always_comb begin
      c_low = carry_in;
      for (int i = 0; i < APPROX_BITS; i++) begin
        want[i] = ~((op_a[i] & op_b[i]) | (op_a[i] & c_low) | (op_b[i] & c_low));
        c_low   = ~want[i];
      end
      assert_sfc_sum_R3: assert (sum[APPROX_BITS-1:0] == want)
        else $error("R3 inverted-carry sum mismatch");
      assert_sfc_carry_R3: assert (seg_carry == c_low)
        else $error("R3 majority carry mismatch");
    end
  end

  if (APPROX_BITS == WIDTH && CELL_KIND == CELL_CARRY_PREDICT) begin : g_r5
    always_comb begin
      assert_full_carry_R5: assert (carry_out ==
        (op_a[WIDTH-1] & op_b[WIDTH-1]))
        else $error("R5 full prediction carry mismatch");
    end
  end
endmodule

bind lpa_adder lpa_adder_checker #(
  .WIDTH(WIDTH), .APPROX_BITS(APPROX_BITS), .CELL_KIND(CELL_KIND)
) u_lpa_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum(sum), .carry_out(carry_out), .seg_carry(seg_carry)
);

// File: tb/tb_lpa_adder.sv
module tb_lpa_adder;
  import lpa_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] a, b;
  logic        cin;
  logic [32:0] got [8];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam int CW [8] = '{12, 12, 12, 8, 12, 24, 32, 12};
  localparam int CK [8] = '{6, 6, 12, 8, 10, 12, 0, 8};
  localparam bit CS [8] = '{0, 1, 0, 1, 1, 0, 0, 0};
  string ctag [8] = '{"R6", "R6", "R5", "R5", "R7", "R8", "R1", "R7"};
  real nmed [8];

  logic [11:0] s0, s1, s2, s4, s7;
  logic [7:0]  s3;
  logic [23:0] s5;
  logic [31:0] s6;
  logic [7:0]  co;

  lpa_adder #(.WIDTH(12), .APPROX_BITS(6), .CELL_KIND(CELL_CARRY_PREDICT)) dut (
    .op_a(a[11:0]), .op_b(b[11:0]), .carry_in(cin), .sum(s0), .carry_out(co[0]));
  lpa_adder #(.WIDTH(12), .APPROX_BITS(6), .CELL_KIND(CELL_SUM_FROM_CARRY)) u_h_sfc (
    .op_a(a[11:0]), .op_b(b[11:0]), .carry_in(cin), .sum(s1), .carry_out(co[1]));
  lpa_adder #(.WIDTH(12), .APPROX_BITS(12), .CELL_KIND(CELL_CARRY_PREDICT)) u_f_cp (
    .op_a(a[11:0]), .op_b(b[11:0]), .carry_in(cin), .sum(s2), .carry_out(co[2]));
  lpa_adder #(.WIDTH(8), .APPROX_BITS(8), .CELL_KIND(CELL_SUM_FROM_CARRY)) u_f_sfc (
    .op_a(a[7:0]), .op_b(b[7:0]), .carry_in(cin), .sum(s3), .carry_out(co[3]));
  lpa_adder #(.WIDTH(12), .APPROX_BITS(10), .CELL_KIND(CELL_SUM_FROM_CARRY)) u_k10 (
    .op_a(a[11:0]), .op_b(b[11:0]), .carry_in(cin), .sum(s4), .carry_out(co[4]));
  lpa_adder #(.WIDTH(24), .APPROX_BITS(12), .CELL_KIND(CELL_CARRY_PREDICT)) u_w24 (
    .op_a(a[23:0]), .op_b(b[23:0]), .carry_in(cin), .sum(s5), .carry_out(co[5]));
  lpa_adder #(.WIDTH(32), .APPROX_BITS(0), .CELL_KIND(CELL_CARRY_PREDICT)) u_exact (
    .op_a(a), .op_b(b), .carry_in(cin), .sum(s6), .carry_out(co[6]));
  lpa_adder #(.WIDTH(12), .APPROX_BITS(8), .CELL_KIND(CELL_CARRY_PREDICT)) u_k8cp (
    .op_a(a[11:0]), .op_b(b[11:0]), .carry_in(cin), .sum(s7), .carry_out(co[7]));

  assign got[0] = {20'd0, co[0], s0};
  assign got[1] = {20'd0, co[1], s1};
  assign got[2] = {20'd0, co[2], s2};
  assign got[3] = {24'd0, co[3], s3};
  assign got[4] = {20'd0, co[4], s4};
  assign got[5] = {8'd0,  co[5], s5};
  assign got[6] = {co[6], s6};
  assign got[7] = {20'd0, co[7], s7};

  function automatic logic [32:0] exact_sum(int w, logic [31:0] x, logic [31:0] y, logic c);
    logic [32:0] m;
    m = (33'd1 << w) - 33'd1;
    return ({1'b0, x} & m) + ({1'b0, y} & m) + {32'd0, c};
  endfunction

  function automatic logic [32:0] cell_model(int w, int k, bit sfc,
                                             logic [31:0] x, logic [31:0] y, logic c);
    logic [32:0] r;
    logic s, nc, cc;
    r  = '0;
    cc = c;
    for (int i = 0; i < w; i++) begin
      if (i < k && !sfc) begin
        s  = x[i] ^ y[i] ^ cc;
        nc = x[i] & y[i];
      end else if (i < k) begin
        nc = (x[i] & y[i]) | (x[i] & cc) | (y[i] & cc);
        s  = ~nc;
      end else begin
        s  = x[i] ^ y[i] ^ cc;
        nc = (x[i] & y[i]) | (x[i] & cc) | (y[i] & cc);
      end
      r[i] = s;
      cc   = nc;
    end
    r[w] = cc;
    return r;
  endfunction

  task automatic check(int cfg, logic [32:0] exp, string tag);
    n_chk++;
    if (got[cfg] !== exp) begin
      n_bad++;
      $display("FAIL %s cfg%0d a=%h b=%h cin=%b actual=%h expected=%h",
               tag, cfg, a, b, cin, got[cfg], exp);
    end
  endtask

  task automatic drive(logic [31:0] x, logic [31:0] y, logic c);
    @(posedge clk);
    a   = x;
    b   = y;
    cin = c;
    @(negedge clk);
  endtask

  task automatic check_all(bit acc);
    logic [32:0] ex, mo;
    real d;
    for (int cfg = 0; cfg < 8; cfg++) begin
      ex = exact_sum(CW[cfg], a, b, cin);
      mo = cell_model(CW[cfg], CK[cfg], CS[cfg], a, b, cin);
      if (CK[cfg] == 0) check(cfg, ex, "R1");
      else              check(cfg, mo, ctag[cfg]);
      if (acc) begin
        d = real'(longint'(got[cfg])) - real'(longint'(ex));
        if (d < 0.0) d = -d;
        nmed[cfg] += d / (real'(longint'(1) << (CW[cfg] + 1)) - 1.0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    for (int i = 0; i < 8; i++) nmed[i] = 0.0;
    void'($urandom(32'd2024));

    // all-zero operands
    drive(32'h0, 32'h0, 1'b0);
    check_all(0);
    // R3: every sum-from-carry cell is wrong on 0,0,0
    check(1, 33'h0_0000_003F, "R3");

    // R2: carry-predicting cell drops the incoming carry
    drive(32'h001, 32'h000, 1'b1);
    check(0, 33'h0_0000_0000, "R2");
    check_all(0);
    drive(32'h03F, 32'h001, 1'b0);
    check(0, 33'h0_0000_003C, "R2");
    check_all(0);

    // R4: boundary carry from top approximate cell into exact part
    drive(32'h020, 32'h020, 1'b0);
    check(0, 33'h0_0000_0040, "R4");
    check_all(0);

    // R3: all-ones triples in the sum-from-carry lower half
    drive(32'hFFF, 32'hFFF, 1'b1);
    check(1, 33'h0_0000_1FC0, "R3");
    check_all(0);

    // R5: full prediction carry out of top cell
    drive(32'h800, 32'h800, 1'b0);
    check(2, 33'h0_0000_1000, "R5");
    drive(32'h400, 32'h400, 1'b0);
    check(2, 33'h0_0000_0800, "R5");
    check_all(0);

    // R1: exact 32-bit wrap
    drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    check(6, 33'h1_0000_0001, "R1");
    check_all(0);
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check_all(0);

    // R8: random mix over every width and split
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = $urandom();
      case ($urandom_range(0, 7))
        0: x = '1;
        1: y = '0;
        2: y = ~x;
        default: ;
      endcase
      drive(x, y, 1'($urandom_range(0, 1)));
      check_all(1);
    end

    for (int cfg = 0; cfg < 8; cfg++)
      $display("cfg%0d W=%0d K=%0d kind=%0d NMED=%g", cfg, CW[cfg], CK[cfg],
               CS[cfg], nmed[cfg] / 3000.0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule